// File: doc/BRIEF.md
# Channel Interrupt Aggregator

This block gathers the service requests of sixteen serial channels into a single level-sensitive interrupt line. Each channel drives one request input. The block keeps a per-channel mask word, a group enable and a card enable. It asserts its interrupt output while at least one unmasked channel is requesting and both enables are on.

Software reaches the block through a small synchronous register port with word addresses. On an interrupt, software reads the live request word and the mask word. It then services every channel that is requesting and not masked. Software updates the mask by read-modify-write. A write takes effect at the clock edge where it is presented. Read data is registered and appears one cycle after the read strobe.

The block comes out of reset with every channel masked and both enables off, so no interrupt can be raised until software has opened all three gates.

Top module: `irqagg_top`

## Requirements
- R1: After reset the mask word reads 0x0000FFFF (every channel masked), the group and card control words read 0, and `irq_o` is 0.
- R2: A read of word 0 (status) returns the request inputs as sampled at the clock edge of the read, in bits 15:0, with upper bits 0.
- R3: A write to word 0 has no effect: status still reflects the request inputs and the mask word is unchanged.
- R4: Word 1 (mask) stores `wdata[15:0]` on a write and reads back those 16 bits with upper bits 0; a 1 in bit n blocks channel n.
- R5: Channel n is pending only when request n is 1 and mask bit n is 0; masked requests never raise `irq_o`.
- R6: Word 2 holds the group enable in bit 20 (other bits read 0); with it clear `irq_o` stays 0.
- R7: Word 3 holds the card enable in bit 0 (other bits read 0); with it clear `irq_o` stays 0.
- R8: `irq_o` is a level: it is 1 in the cycle after any channel is pending with both enables set, and falls in the cycle after that condition ends.
- R9: `rdata` changes only in the cycle after a read strobe and holds its value otherwise.
- R10: Words 4 to 7 are unmapped: they read 0 and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_i | input | 16 | Per-channel request lines |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 3 | Word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| irq_o | output | 1 | Combined level interrupt |

## Verification
The assertions assume that the request lines are synchronous to `clk`. They also assume that write and read strobes are never unknown once reset is released, and that the address is a defined value whenever a strobe is high. The stimulus drives every input on the falling edge and holds each strobe for exactly one cycle. It keeps the strobes low throughout reset and changes the request word only between register accesses, so every sampled value is settled.

// File: rtl/irqagg_pkg.sv
// Shared constants for the interrupt aggregator: word offsets of the
// register port and the bit positions of the two enable flags.
// Assumes a register data path of at least 21 bits.
package irqagg_pkg;
    localparam int unsigned OFF_STATUS  = 0;
    localparam int unsigned OFF_MASK    = 1;
    localparam int unsigned OFF_GROUP   = 2;
    localparam int unsigned OFF_CARD    = 3;
    localparam int unsigned GRP_EN_BIT  = 20;
    localparam int unsigned CARD_EN_BIT = 0;
endpackage

// File: rtl/irqagg_regs.sv
// Register file of the aggregator: mask word, group enable, card enable,
// plus a registered read port that also exposes the live request lines.
// Assumes single-cycle strobes and at most one access per cycle.
module irqagg_regs
    import irqagg_pkg::*;
#(
    parameter int unsigned NUM_CH = 16,
    parameter int unsigned ADDR_W = 3,
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] req_i,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic [NUM_CH-1:0] mask_q,
    output logic              grp_en_q,
    output logic              card_en_q
);
    localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(OFF_STATUS);
    localparam logic [ADDR_W-1:0] A_MASK   = ADDR_W'(OFF_MASK);
    localparam logic [ADDR_W-1:0] A_GROUP  = ADDR_W'(OFF_GROUP);
    localparam logic [ADDR_W-1:0] A_CARD   = ADDR_W'(OFF_CARD);

    logic [DATA_W-1:0] rd_word;

    // Update the writable control state; status and unmapped words ignore writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q    <= '1;
            grp_en_q  <= 1'b0;
            card_en_q <= 1'b0;
        end else if (wr_en) begin
            case (addr)
                A_MASK:  mask_q    <= wdata[NUM_CH-1:0];
                A_GROUP: grp_en_q  <= wdata[GRP_EN_BIT];
                A_CARD:  card_en_q <= wdata[CARD_EN_BIT];
                default: ;
            endcase
        end
    end

    // Select the word addressed by the current read.
    always_comb begin
        rd_word = '0;
        case (addr)
            A_STATUS: rd_word = DATA_W'(req_i);
            A_MASK:   rd_word = DATA_W'(mask_q);
            A_GROUP:  rd_word[GRP_EN_BIT]  = grp_en_q;
            A_CARD:   rd_word[CARD_EN_BIT] = card_en_q;
            default:  rd_word = '0;
        endcase
    end

    // Capture read data on a read strobe and hold it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (rd_en) begin
            rdata <= rd_word;
        end
    end

    AST_MASK_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (mask_q == {NUM_CH{1'b1}}) && !grp_en_q && !card_en_q); // R1

    AST_STATUS_RO: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == A_STATUS) |=> $stable(mask_q)); // R3

    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(rd_en) && !$past(!rst_n)) |-> $stable(rdata)); // R9

    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr > A_CARD) |=> (rdata == '0)); // R10
endmodule

// File: rtl/irqagg_combine.sv
// Combines request lines, mask and the two enables into one registered
// level interrupt. Assumes request lines are synchronous to clk.
module irqagg_combine #(
    parameter int unsigned NUM_CH = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] req_i,
    input  logic [NUM_CH-1:0] mask_q,
    input  logic              grp_en_q,
    input  logic              card_en_q,
    output logic              irq_o
);
    logic [NUM_CH-1:0] pend;
    logic              any_pend;

    // Per-channel pending: requesting and not blocked by its mask bit.
    always_comb begin
        pend     = req_i & ~mask_q;
        any_pend = |pend;
    end

    // Register the gated interrupt level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_o <= 1'b0;
        end else begin
            irq_o <= any_pend && grp_en_q && card_en_q;
        end
    end

    AST_IRQ_NEEDS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> $past(|(req_i & ~mask_q))); // R5

    AST_IRQ_NEEDS_GROUP: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> $past(grp_en_q)); // R6

    AST_IRQ_NEEDS_CARD: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> $past(card_en_q)); // R7

    AST_IRQ_FALLS: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i == '0) |=> !irq_o); // R8
endmodule

// File: rtl/irqagg_top.sv
// Top of the channel interrupt aggregator: register file plus combining
// logic. Assumes synchronous inputs and a synchronous active-low reset.
module irqagg_top #(
    parameter int unsigned NUM_CH = 16,
    parameter int unsigned ADDR_W = 3,
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] req_i,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              irq_o
);
    logic [NUM_CH-1:0] mask_q;
    logic              grp_en_q;
    logic              card_en_q;

    irqagg_regs #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .req_i(req_i), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .mask_q(mask_q),
        .grp_en_q(grp_en_q), .card_en_q(card_en_q)
    );

    irqagg_combine #(.NUM_CH(NUM_CH)) u_comb (
        .clk(clk), .rst_n(rst_n), .req_i(req_i), .mask_q(mask_q),
        .grp_en_q(grp_en_q), .card_en_q(card_en_q), .irq_o(irq_o)
    );
endmodule

// File: tb/sim_irqagg_top.sv
module sim_irqagg_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] req_i = '0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [2:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq_o;
    int checks = 0;
    int errors = 0;
    logic [31:0] got;
    logic [31:0] held;

    always #4 clk = ~clk;

    irqagg_top u0 (.clk(clk), .rst_n(rst_n), .req_i(req_i), .wr_en(wr_en),
        .rd_en(rd_en), .addr(addr), .wdata(wdata), .rdata(rdata), .irq_o(irq_o));

    // vector: {req, mask, group_en, card_en, expected irq}
    localparam logic [34:0] VEC [8] = '{
        {16'h0001, 16'hFFFF, 1'b1, 1'b1, 1'b0},
        {16'h0001, 16'hFFFE, 1'b1, 1'b1, 1'b1},
        {16'h8000, 16'h7FFF, 1'b1, 1'b1, 1'b1},
        {16'h8000, 16'h7FFF, 1'b0, 1'b1, 1'b0},
        {16'h8000, 16'h7FFF, 1'b1, 1'b0, 1'b0},
        {16'hF0F0, 16'hF0F0, 1'b1, 1'b1, 1'b0},
        {16'h0000, 16'h0000, 1'b1, 1'b1, 1'b0},
        {16'hFFFF, 16'h0000, 1'b1, 1'b1, 1'b1}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk); rd_en = 1'b1; addr = a;
        @(negedge clk); rd_en = 1'b0; d = rdata;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 irq", {31'd0, irq_o}, 32'd0);
        rd(3'd1, got); check("R1 mask", got, 32'h0000FFFF);
        rd(3'd2, got); check("R1 group", got, 32'd0);
        rd(3'd3, got); check("R1 card", got, 32'd0);

        req_i = 16'hA5A5; rd(3'd0, got); check("R2 status a", got, 32'h0000A5A5);
        req_i = 16'h5A3C; rd(3'd0, got); check("R2 status b", got, 32'h00005A3C);

        wr(3'd0, 32'hFFFF_0000);
        rd(3'd0, got); check("R3 status", got, 32'h00005A3C);
        rd(3'd1, got); check("R3 mask", got, 32'h0000FFFF);

        wr(3'd1, 32'h1234_ABCD);
        rd(3'd1, got); check("R4 mask", got, 32'h0000ABCD);
        wr(3'd2, 32'hFFFF_FFFF);
        rd(3'd2, got); check("R6 group", got, 32'h0010_0000);
        wr(3'd3, 32'hFFFF_FFFF);
        rd(3'd3, got); check("R7 card", got, 32'h0000_0001);

        wr(3'd6, 32'h0000_0000);
        rd(3'd5, got); check("R10 unmapped read", got, 32'd0);
        rd(3'd1, got); check("R10 mask kept", got, 32'h0000ABCD);

        // R9: rdata holds with no read strobe while inputs change
        held = rdata; req_i = 16'h1111; addr = 3'd0;
        repeat (3) @(negedge clk);
        check("R9 hold", rdata, held);

        for (int i = 0; i < 8; i++) begin
            wr(3'd1, {16'd0, VEC[i][18:3]});
            wr(3'd2, {11'd0, VEC[i][2], 20'd0});
            wr(3'd3, {31'd0, VEC[i][1]});
            @(negedge clk); req_i = VEC[i][34:19];
            @(negedge clk);
            check($sformatf("R5 R6 R7 R8 vec%0d", i), {31'd0, irq_o}, {31'd0, VEC[i][0]});
        end

        // R8: level falls one cycle after the last request drops
        @(negedge clk); req_i = 16'h0000;
        @(negedge clk);
        check("R8 fall", {31'd0, irq_o}, 32'd0);
        req_i = 16'h0040;
        @(negedge clk);
        check("R8 rise", {31'd0, irq_o}, 32'd1);
        // R5: masking the only requester clears the interrupt
        wr(3'd1, 32'h0000_0040);
        @(negedge clk);
        check("R5 masked", {31'd0, irq_o}, 32'd0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule